// File: doc/BRIEF.md
# Serial Download Entry Controller

This controller makes the start-up choice between a serial code download and a normal boot from flash. Straight after reset it looks once at a shared sense line that idles high. An external programmer holds that line low. If the line is low, the controller acknowledges by pulling its transmit line low. It then waits for a short clock preamble on the sense line, reads a 16-bit word count, and writes that many 16-bit code words into a buffer through a simple write port.

Every download phase has its own deadline, measured in milliseconds and converted to clock cycles from a clock-frequency parameter. If any deadline is missed, the controller quietly gives up and raises a sticky fallback flag, so the rest of the system boots normally. When the last announced word has been stored, it gives a single done pulse and then ignores its inputs.

Top module: `boot_entry_ctrl`

## Requirements
- R1: On the first clock edge after reset is released, the controller samples `sense_clk` once. If it is low, download mode begins. If it is high, `fallback` is set at that edge.
- R2: `ack_tx` is high during reset. It goes low at the edge that begins download mode and stays low until the count has been received.
- R3: After the acknowledge, three rising edges of `sense_clk` must arrive within PRE_MS milliseconds, which is PRE_MS*CLK_HZ/1000 cycles counted from entry to the phase. If they do not, `fallback` is set.
- R4: The count is 16 bits, taken from `rx_data` on rising edges of `sense_clk`, most significant bit first, so the high byte comes first. All 16 bits must arrive within CNT_MS milliseconds of the end of the preamble. If they do not, `fallback` is set.
- R5: `ack_tx` returns high at the edge where the 16th count bit is taken. It stays high after any fallback.
- R6: Each code word is 16 bits, MSB first, sampled the same way as the count. Each word must complete within WORD_MS milliseconds of the previous word, or of the count for the first word. If it does not, `fallback` is set.
- R7: Each completed word gives exactly one cycle of `wr_en`, with `wr_data` holding the word and `wr_addr` holding its index. Indices run 0, 1, 2 and so on.
- R8: `done` is a single-cycle pulse. It is raised together with the write of the last announced word, or at the count edge when the count is zero. After it, no further writes occur.
- R9: `fallback` stays set until reset. While it is set there are no writes and no done pulse, whatever the input lines do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sense_clk | input | 1 | Shared line: programmer-present sense, preamble and serial bit clock |
| rx_data | input | 1 | Serial data from the programmer |
| ack_tx | output | 1 | Acknowledge line to the programmer, idles high |
| wr_en | output | 1 | One-cycle write strobe for a received code word |
| wr_addr | output | 16 | Word index of the write |
| wr_data | output | 16 | Received code word |
| done | output | 1 | One-cycle pulse when the whole image has been received |
| fallback | output | 1 | Sticky flag: boot normally from flash |

## Verification
The assertions assume that `sense_clk` and `rx_data` are already synchronous to `clk`. They also assume that `rx_data` is stable in the cycle in which a rising edge of `sense_clk` is seen. The stimulus keeps to this by changing both lines only on the falling clock edge, and by setting each data bit in the same cycle as the rising edge that samples it, holding it for two cycles. Deadlines are scaled down through a small clock-frequency parameter, so that each phase's limit can be approached from both sides within a short run.

// File: rtl/boot_entry_pkg.sv
package boot_entry_pkg;

    localparam int unsigned WORD_W         = 16;
    localparam int unsigned PREAMBLE_EDGES = 3;

    typedef enum logic [2:0] {
        ST_DETECT,
        ST_PREAMBLE,
        ST_COUNT,
        ST_WORDS,
        ST_STOP,
        ST_FALLBACK
    } boot_state_e;

    typedef struct packed {
        logic              stb;
        logic [WORD_W-1:0] data;
    } rx_word_t;

    function automatic int unsigned ms_to_cycles(input int unsigned clk_hz,
                                                 input int unsigned ms);
        return (clk_hz / 1000) * ms;
    endfunction

endpackage

// File: rtl/boot_line_sampler.sv
module boot_line_sampler
    import boot_entry_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     sense_clk,
    input  logic     rx_data,
    output logic     rise,
    output rx_word_t word
);
    localparam int unsigned BW = $clog2(WORD_W);
    localparam logic [BW-1:0] LAST_BIT = BW'(WORD_W - 1);

    logic              sense_q;
    logic [BW-1:0]     bit_cnt;
    logic [WORD_W-1:0] shreg;

    assign rise      = sense_clk & ~sense_q;
    assign word.stb  = en & rise & (bit_cnt == LAST_BIT);
    assign word.data = {shreg[WORD_W-2:0], rx_data};

    always_ff @(posedge clk) begin
        if (rst) begin
            sense_q <= 1'b1;
            bit_cnt <= '0;
            shreg   <= '0;
        end else begin
            sense_q <= sense_clk;
            if (!en) begin
                bit_cnt <= '0;
            end else if (rise) begin
                shreg   <= {shreg[WORD_W-2:0], rx_data};
                bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
            end
        end
    end

    assert_stb_needs_en_R4: assert property (@(posedge clk) disable iff (rst)
        word.stb |-> (en && sense_clk));

endmodule

// File: rtl/boot_phase_timer.sv
module boot_phase_timer #(
    parameter int unsigned TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             run,
    input  logic [TMR_W-1:0] limit,
    output logic             expired
);
    logic [TMR_W-1:0] cnt;

    assign expired = run & (cnt == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + 1'b1;
        end
    end

    assert_timer_bound_R3: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt < limit));

endmodule

// File: rtl/boot_entry_ctrl.sv
module boot_entry_ctrl
    import boot_entry_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 100_000_000,
    parameter int unsigned PRE_MS  = 15,
    parameter int unsigned CNT_MS  = 1,
    parameter int unsigned WORD_MS = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sense_clk,
    input  logic              rx_data,
    output logic              ack_tx,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              done,
    output logic              fallback
);
    localparam int unsigned LIM_PRE  = ms_to_cycles(CLK_HZ, PRE_MS);
    localparam int unsigned LIM_CNT  = ms_to_cycles(CLK_HZ, CNT_MS);
    localparam int unsigned LIM_WORD = ms_to_cycles(CLK_HZ, WORD_MS);
    localparam int unsigned LIM_MAX  = (LIM_PRE > LIM_CNT)
                                     ? ((LIM_PRE > LIM_WORD) ? LIM_PRE : LIM_WORD)
                                     : ((LIM_CNT > LIM_WORD) ? LIM_CNT : LIM_WORD);
    localparam int unsigned TMR_W    = $clog2(LIM_MAX + 1);
    localparam logic [1:0]  LAST_EDGE = 2'(PREAMBLE_EDGES - 1);

    boot_state_e       state;
    logic [1:0]        edges;
    logic [WORD_W-1:0] count;
    logic [WORD_W-1:0] wcnt;
    logic              rise;
    rx_word_t          word;
    logic              timed, advance, tmo, pre_done;
    logic [TMR_W-1:0]  limit;

    boot_line_sampler u_sampler (
        .clk       (clk),
        .rst       (rst),
        .en        ((state == ST_COUNT) || (state == ST_WORDS)),
        .sense_clk (sense_clk),
        .rx_data   (rx_data),
        .rise      (rise),
        .word      (word)
    );

    always_comb begin
        pre_done = (state == ST_PREAMBLE) && rise && (edges == LAST_EDGE);
        timed    = 1'b1;
        advance  = 1'b0;
        limit    = TMR_W'(LIM_PRE);
        unique case (state)
            ST_PREAMBLE: advance = pre_done;
            ST_COUNT: begin
                advance = word.stb;
                limit   = TMR_W'(LIM_CNT);
            end
            ST_WORDS: begin
                advance = word.stb;
                limit   = TMR_W'(LIM_WORD);
            end
            default: timed = 1'b0;
        endcase
    end

    boot_phase_timer #(.TMR_W(TMR_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clr     (advance | ~timed),
        .run     (timed),
        .limit   (limit),
        .expired (tmo)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_DETECT;
            ack_tx   <= 1'b1;
            fallback <= 1'b0;
            done     <= 1'b0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            edges    <= '0;
            count    <= '0;
            wcnt     <= '0;
        end else begin
            done  <= 1'b0;
            wr_en <= 1'b0;
            unique case (state)
                ST_DETECT: begin
                    if (!sense_clk) begin
                        state  <= ST_PREAMBLE;
                        ack_tx <= 1'b0;
                        edges  <= '0;
                    end else begin
                        state    <= ST_FALLBACK;
                        fallback <= 1'b1;
                    end
                end
                ST_PREAMBLE: begin
                    if (pre_done) begin
                        state <= ST_COUNT;
                    end else if (tmo) begin
                        state    <= ST_FALLBACK;
                        fallback <= 1'b1;
                        ack_tx   <= 1'b1;
                    end else if (rise) begin
                        edges <= edges + 1'b1;
                    end
                end
                ST_COUNT: begin
                    if (word.stb) begin
                        count  <= word.data;
                        ack_tx <= 1'b1;
                        wcnt   <= '0;
                        if (word.data == '0) begin
                            done  <= 1'b1;
                            state <= ST_STOP;
                        end else begin
                            state <= ST_WORDS;
                        end
                    end else if (tmo) begin
                        state    <= ST_FALLBACK;
                        fallback <= 1'b1;
                        ack_tx   <= 1'b1;
                    end
                end
                ST_WORDS: begin
                    if (word.stb) begin
                        wr_en   <= 1'b1;
                        wr_data <= word.data;
                        wr_addr <= wcnt;
                        wcnt    <= wcnt + 1'b1;
                        if ((wcnt + 1'b1) == count) begin
                            done  <= 1'b1;
                            state <= ST_STOP;
                        end
                    end else if (tmo) begin
                        state    <= ST_FALLBACK;
                        fallback <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assert_ack_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !ack_tx |-> (!wr_en && !done && !fallback));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_no_write_after_done_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !wr_en);

    assert_fallback_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        fallback |=> fallback);

    assert_fallback_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        fallback |-> (!wr_en && !done && ack_tx));

endmodule

// File: tb/tb_boot_entry_ctrl.sv
module tb_boot_entry_ctrl;
    localparam int unsigned CLK_HZ = 50_000;
    localparam int LIM_PRE  = 15 * (CLK_HZ / 1000);
    localparam int LIM_CNT  = 1 * (CLK_HZ / 1000);
    localparam int LIM_WORD = 10 * (CLK_HZ / 1000);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sense_clk = 1'b1;
    logic        rx_data = 1'b0;
    logic        ack_tx, wr_en, done, fallback;
    logic [15:0] wr_addr, wr_data;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    boot_entry_ctrl #(.CLK_HZ(CLK_HZ)) dut (
        .clk(clk), .rst(rst), .sense_clk(sense_clk), .rx_data(rx_data),
        .ack_tx(ack_tx), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .done(done), .fallback(fallback)
    );

    // Behavioural reference: phase 0 detect, 1 preamble, 2 count, 3 words, 4 stopped, 5 fallback
    int   ph, tmr, nrise, nbits, nwords, announced;
    int   acc;
    logic prev;
    logic m_tx, m_fb, m_done, m_wr;
    int   m_addr, m_data;
    bit   armed = 1'b0;

    always @(posedge clk) begin
        armed = 1'b1;
        m_done = 1'b0;
        m_wr = 1'b0;
        if (rst) begin
            ph = 0; tmr = 0; nrise = 0; nbits = 0; nwords = 0; acc = 0;
            m_tx = 1'b1; m_fb = 1'b0; m_addr = 0; m_data = 0;
            prev = 1'b1;
        end else begin
            case (ph)
                0: if (!sense_clk) begin ph = 1; m_tx = 1'b0; tmr = 0; nrise = 0; end
                   else begin ph = 5; m_fb = 1'b1; end
                1: begin
                    if (sense_clk && !prev) nrise++;
                    if (nrise == 3) begin ph = 2; tmr = 0; nbits = 0; acc = 0; end
                    else if (tmr == LIM_PRE - 1) begin ph = 5; m_fb = 1'b1; m_tx = 1'b1; end
                    else tmr++;
                end
                2, 3: begin
                    if (sense_clk && !prev) begin
                        acc = ((acc << 1) | int'(rx_data)) & 16'hffff;
                        nbits++;
                    end
                    if (nbits == 16) begin
                        tmr = 0; nbits = 0;
                        if (ph == 2) begin
                            announced = acc; m_tx = 1'b1; nwords = 0;
                            if (announced == 0) begin m_done = 1'b1; ph = 4; end
                            else ph = 3;
                        end else begin
                            m_wr = 1'b1; m_addr = nwords; m_data = acc;
                            nwords++;
                            if (nwords == announced) begin m_done = 1'b1; ph = 4; end
                        end
                        acc = 0;
                    end else if (tmr == ((ph == 2) ? LIM_CNT : LIM_WORD) - 1) begin
                        ph = 5; m_fb = 1'b1; m_tx = 1'b1;
                    end else tmr++;
                end
                default: ;
            endcase
        end
        prev = sense_clk;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    int obs_data[$];
    int obs_addr[$];
    int done_seen = 0;

    always @(negedge clk) begin
        if (armed) begin
            chk("R2 R5", "ack_tx", int'(ack_tx), int'(m_tx));
            chk("R1 R3 R4 R6 R9", "fallback", int'(fallback), int'(m_fb));
            chk("R8", "done", int'(done), int'(m_done));
            chk("R7", "wr_en", int'(wr_en), int'(m_wr));
            if (m_wr && wr_en) begin
                chk("R7", "wr_addr", int'(wr_addr), m_addr);
                chk("R7", "wr_data", int'(wr_data), m_data);
            end
            if (wr_en) begin obs_data.push_back(int'(wr_data)); obs_addr.push_back(int'(wr_addr)); end
            if (done) done_seen++;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic line);
        @(negedge clk);
        rst = 1'b1; sense_clk = line; rx_data = 1'b0;
        idle(3);
        rst = 1'b0;
        obs_data.delete(); obs_addr.delete(); done_seen = 0;
        idle(1);
    endtask

    task automatic pulse();
        sense_clk = 1'b1; idle(1);
        sense_clk = 1'b0; idle(1);
    endtask

    task automatic send_bit(input logic b, input int gap);
        rx_data = b; sense_clk = 1'b1; idle(1);
        sense_clk = 1'b0; idle(1 + gap);
    endtask

    task automatic send_word(input logic [15:0] w, input int gap);
        for (int i = 15; i >= 0; i--) send_bit(w[i], gap);
    endtask

    initial begin
        // R1: line high at start gives normal boot
        do_reset(1'b1);
        chk("R1", "fallback high-line", int'(fallback), 1);
        chk("R2", "ack idle high", int'(ack_tx), 1);
        pulse(); send_word(16'h0001, 0); idle(4);
        chk("R9", "no write after fallback", obs_data.size(), 0);

        // R2 R3 R4 R5 R6 R7 R8: full download of three words
        do_reset(1'b0);
        chk("R2", "ack low", int'(ack_tx), 0);
        idle(10);
        pulse(); pulse(); pulse();
        send_word(16'h0003, 0);
        chk("R5", "ack high after count", int'(ack_tx), 1);
        send_word(16'hA5A5, 0);
        idle(LIM_WORD - 40);
        send_word(16'h1234, 0);
        send_word(16'hFFFF, 0);
        idle(3);
        chk("R7", "write count", obs_data.size(), 3);
        if (obs_data.size() == 3) begin
            chk("R7", "word0", obs_data[0], 16'hA5A5);
            chk("R7", "word1", obs_data[1], 16'h1234);
            chk("R7", "word2", obs_data[2], 16'hFFFF);
            chk("R7", "addr2", obs_addr[2], 2);
        end
        chk("R8", "one done", done_seen, 1);
        send_word(16'h5555, 0); idle(LIM_WORD + 5);
        chk("R8", "stopped after done", obs_data.size(), 3);
        chk("R8", "no fallback after done", int'(fallback), 0);

        // R8: zero count finishes at once
        do_reset(1'b0);
        pulse(); pulse(); pulse();
        send_word(16'h0000, 0);
        idle(2);
        chk("R8", "zero count done", done_seen, 1);
        chk("R5", "ack high zero count", int'(ack_tx), 1);

        // R3: preamble too short
        do_reset(1'b0);
        pulse(); pulse();
        idle(LIM_PRE + 5);
        chk("R3", "preamble timeout", int'(fallback), 1);
        chk("R5", "ack released on fallback", int'(ack_tx), 1);
        pulse(); send_word(16'h0002, 0); send_word(16'h1111, 0); idle(3);
        chk("R9", "fallback ignores lines", obs_data.size(), 0);

        // R3: preamble finishing just inside and just outside the deadline
        do_reset(1'b0);
        idle(LIM_PRE - 8);
        pulse(); pulse(); pulse();
        idle(2);
        chk("R3", "late preamble accepted", int'(fallback), 0);
        do_reset(1'b0);
        idle(LIM_PRE - 4);
        pulse(); pulse(); pulse();
        idle(2);
        chk("R3", "too-late preamble", int'(fallback), 1);

        // R4: count too slow
        do_reset(1'b0);
        pulse(); pulse(); pulse();
        send_word(16'h0004, 3);
        idle(2);
        chk("R4", "count timeout", int'(fallback), 1);

        // R6: second word never arrives
        do_reset(1'b0);
        pulse(); pulse(); pulse();
        send_word(16'h0002, 0);
        send_word(16'hBEEF, 0);
        idle(LIM_WORD + 5);
        chk("R6", "word timeout", int'(fallback), 1);
        chk("R6", "one write before timeout", obs_data.size(), 1);
        send_word(16'hCAFE, 0); idle(3);
        chk("R9", "no late write", obs_data.size(), 1);
        chk("R9", "no done", done_seen, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule